// File: doc/BRIEF.md
# Ring Routing Station

This block is one stop on a one-way ring that carries many logical, named links between endpoints spread over a chip. Each message travelling the ring is tagged with a small numeric link number. At build time every station is given two constant lists. The first says which link numbers end at this station. The second says which number each local send port stamps on its traffic. An arriving message whose number is on the first list leaves through the local receive port. Any other message moves on to the next station.

Local endpoints see a plain valid/ready pair, just as they would on a direct wire, and the station supplies the link number itself. Traffic already on the ring always wins over new local traffic. A local port is offered the outgoing slot only when no ring message needs it. When several send ports compete, the lowest-numbered port wins. The outgoing ring link and the local receive port are each held in one register, so every hop costs one cycle. A receiver that is not ready makes the station stall the incoming ring link, so no message is ever dropped.

With default parameters the delivery list is {5, 9}, with 4-bit link numbers and 8-bit data. Send port 0 stamps 12 and send port 1 stamps 3.

Top module: `ring_station`

## Requirements
- R1: After reset is released, `ring_out_valid` and `rx_valid` are both 0.
- R2: A ring message whose number is on the delivery list (default 5 or 9) is taken when `ring_in_ready` is 1. It appears on `rx_valid`/`rx_addr`/`rx_data` one cycle later, with its number and data unchanged.
- R3: A ring message whose number is not on the list is taken when `ring_in_ready` is 1. It appears on `ring_out_*` one cycle later, unchanged.
- R4: While a message that is not on the list is waiting at `ring_in`, every `tx_ready` bit is 0.
- R5: A local send port can see `tx_ready` = 1 only when the outgoing register is empty or `ring_out_ready` is 1.
- R6: Send port 0 has priority over send port 1: `tx_ready[1]` is 0 whenever `tx_valid[0]` is 1.
- R7: A message accepted from send port i leaves on `ring_out` one cycle later. It carries that port's fixed number (port 0 stamps 12, port 1 stamps 3) and the port's data from `tx_data[i*8 +: 8]`.
- R8: A listed message arriving while the receive register is full and `rx_ready` is 0 sees `ring_in_ready` = 0. It is delivered later, not lost.
- R9: While `ring_out_valid` = 1 and `ring_out_ready` = 0, the outgoing message holds steady. The same holds for `rx_*` while `rx_ready` = 0.
- R10: A listed message stalled at `ring_in` does not block injection from a send port when the outgoing register can accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_valid | input | 1 | Upstream ring message present |
| ring_in_ready | output | 1 | Station takes the upstream message |
| ring_in_addr | input | ADDR_W | Link number of upstream message |
| ring_in_data | input | DATA_W | Payload of upstream message |
| ring_out_valid | output | 1 | Message offered to next station |
| ring_out_ready | input | 1 | Next station takes the message |
| ring_out_addr | output | ADDR_W | Link number toward next station |
| ring_out_data | output | DATA_W | Payload toward next station |
| tx_valid | input | N_TX | Per send port: message present |
| tx_ready | output | N_TX | Per send port: message accepted |
| tx_data | input | N_TX*DATA_W | Send port payloads, port i at bits i*DATA_W |
| rx_valid | output | 1 | Delivered message present |
| rx_ready | input | 1 | Local receiver takes the message |
| rx_addr | output | ADDR_W | Link number of delivered message |
| rx_data | output | DATA_W | Payload of delivered message |

## Verification
The assertions assume only that inputs carry known 0/1 values once reset is released. They do not assume that upstream or local senders hold a message steady until it is taken, so the station must stay correct even when a valid is withdrawn. The stimulus therefore draws fresh random valids, link numbers and readies on every cycle. It mixes listed numbers, unlisted ones and the extreme values 0 and 15. It runs phases with ready inputs mostly high, mostly low and balanced, so that both the stall paths and the full-throughput paths are exercised.

// File: rtl/ring_station_pkg.sv
package ring_station_pkg;

  // A one-entry holding register can take a new item when it is empty
  // or when its current item leaves in the same cycle.
  function automatic logic slot_can_load(input logic held, input logic drain);
    return (!held) || drain;
  endfunction

  // A local port may use the outgoing slot only if no ring message wants it.
  function automatic logic inject_window(input logic out_free,
                                         input logic ring_v,
                                         input logic ring_hit);
    return out_free && !(ring_v && !ring_hit);
  endfunction

endpackage

// File: rtl/ring_addr_match.sv
module ring_addr_match #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned N_LOCAL = 2,
  parameter logic [N_LOCAL*ADDR_W-1:0] LOCAL_ADDRS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [N_LOCAL-1:0] eq;

  for (genvar k = 0; k < N_LOCAL; k++) begin : g_cmp
    localparam logic [ADDR_W-1:0] ENTRY = LOCAL_ADDRS[k*ADDR_W +: ADDR_W];
    assign eq[k] = (addr == ENTRY);
  end

  assign hit = |eq;
endmodule

// File: rtl/ring_tx_arbiter.sv
module ring_tx_arbiter #(
  parameter int unsigned N_TX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            avail,
  input  logic [N_TX-1:0] req,
  output logic [N_TX-1:0] ready,
  output logic [N_TX-1:0] grant
);
  logic [N_TX:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N_TX; i++) begin : g_pri
    assign ready[i]     = avail && !blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign grant = ready & req;

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  low_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (N_TX > 1 && req[0]) |-> !ready[N_TX-1]);
endmodule

// File: rtl/ring_slot_reg.sv
module ring_slot_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         drain,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         free
);
  import ring_station_pkg::*;

  assign free = slot_can_load(valid, drain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !drain) |=> (valid && $stable(data)));

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || drain));
endmodule

// File: rtl/ring_station.sv
module ring_station #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned N_LOCAL = 2,
  parameter int unsigned N_TX    = 2,
  parameter logic [N_LOCAL*ADDR_W-1:0] LOCAL_ADDRS = {4'd5, 4'd9},
  parameter logic [N_TX*ADDR_W-1:0]    TX_ADDRS    = {4'd3, 4'd12}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ring_in_valid,
  output logic                   ring_in_ready,
  input  logic [ADDR_W-1:0]      ring_in_addr,
  input  logic [DATA_W-1:0]      ring_in_data,
  output logic                   ring_out_valid,
  input  logic                   ring_out_ready,
  output logic [ADDR_W-1:0]      ring_out_addr,
  output logic [DATA_W-1:0]      ring_out_data,
  input  logic [N_TX-1:0]        tx_valid,
  output logic [N_TX-1:0]        tx_ready,
  input  logic [N_TX*DATA_W-1:0] tx_data,
  output logic                   rx_valid,
  input  logic                   rx_ready,
  output logic [ADDR_W-1:0]      rx_addr,
  output logic [DATA_W-1:0]      rx_data
);
  import ring_station_pkg::*;

  localparam int unsigned MSG_W = ADDR_W + DATA_W;

  // Named internal events
  logic              in_hit;
  logic              out_free, rx_free;
  logic              fwd_fire, dlv_fire, inj_fire, inj_avail;
  logic [N_TX-1:0]   grant;
  logic [MSG_W-1:0]  inj_msg, out_load_msg, out_msg, rx_msg;
  logic              out_load;

  ring_addr_match #(
    .ADDR_W(ADDR_W), .N_LOCAL(N_LOCAL), .LOCAL_ADDRS(LOCAL_ADDRS)
  ) u_match (
    .addr(ring_in_addr),
    .hit (in_hit)
  );

  assign inj_avail = inject_window(out_free, ring_in_valid, in_hit);

  ring_tx_arbiter #(.N_TX(N_TX)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .avail(inj_avail),
    .req  (tx_valid),
    .ready(tx_ready),
    .grant(grant)
  );

  always_comb begin
    inj_msg = '0;
    for (int i = 0; i < N_TX; i++) begin
      if (grant[i]) begin
        inj_msg = {TX_ADDRS[i*ADDR_W +: ADDR_W], tx_data[i*DATA_W +: DATA_W]};
      end
    end
  end

  assign ring_in_ready = in_hit ? rx_free : out_free;
  assign fwd_fire      = ring_in_valid && !in_hit && out_free;
  assign dlv_fire      = ring_in_valid && in_hit && rx_free;
  assign inj_fire      = |grant;
  assign out_load      = fwd_fire || inj_fire;
  assign out_load_msg  = fwd_fire ? {ring_in_addr, ring_in_data} : inj_msg;

  ring_slot_reg #(.W(MSG_W)) u_out_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (out_load),
    .load_data(out_load_msg),
    .drain    (ring_out_ready),
    .valid    (ring_out_valid),
    .data     (out_msg),
    .free     (out_free)
  );

  ring_slot_reg #(.W(MSG_W)) u_rx_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dlv_fire),
    .load_data({ring_in_addr, ring_in_data}),
    .drain    (rx_ready),
    .valid    (rx_valid),
    .data     (rx_msg),
    .free     (rx_free)
  );

  assign {ring_out_addr, ring_out_data} = out_msg;
  assign {rx_addr, rx_data}             = rx_msg;

  // R4
  ring_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_valid && !in_hit) |-> (tx_ready == '0));

  // R5
  inject_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_ready) |-> (!ring_out_valid || ring_out_ready));

  // R2
  deliver_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_valid && ring_in_ready && in_hit) |=>
      (rx_valid && rx_addr == $past(ring_in_addr) && rx_data == $past(ring_in_data)));

  // R3
  forward_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_valid && ring_in_ready && !in_hit) |=>
      (ring_out_valid && ring_out_addr == $past(ring_in_addr)
       && ring_out_data == $past(ring_in_data)));

  // R7
  inject_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_valid & tx_ready)) |=> ring_out_valid);

  // R8
  stall_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_valid && in_hit && rx_valid && !rx_ready) |-> !ring_in_ready);

  // R10
  stall_keeps_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_valid && in_hit && tx_valid[0] && (!ring_out_valid || ring_out_ready))
      |-> tx_ready[0]);
endmodule

// File: tb/tb_ring_station.sv
module tb_ring_station;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ring_in_valid, ring_in_ready;
  logic [3:0]  ring_in_addr;
  logic [7:0]  ring_in_data;
  logic        ring_out_valid, ring_out_ready;
  logic [3:0]  ring_out_addr;
  logic [7:0]  ring_out_data;
  logic [1:0]  tx_valid, tx_ready;
  logic [15:0] tx_data;
  logic        rx_valid, rx_ready;
  logic [3:0]  rx_addr;
  logic [7:0]  rx_data;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  ring_station dut (
    .clk(clk), .rst_n(rst_n),
    .ring_in_valid(ring_in_valid), .ring_in_ready(ring_in_ready),
    .ring_in_addr(ring_in_addr), .ring_in_data(ring_in_data),
    .ring_out_valid(ring_out_valid), .ring_out_ready(ring_out_ready),
    .ring_out_addr(ring_out_addr), .ring_out_data(ring_out_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_addr(rx_addr), .rx_data(rx_data)
  );

  // Reference model state
  bit m_out_v, m_rx_v;
  int m_out_a, m_out_d, m_rx_a, m_rx_d;
  bit m_out_held, m_rx_held;
  string m_out_tag;

  function automatic bit listed(int a);
    return (a == 5) || (a == 9);
  endfunction

  function automatic int stamp(int port);
    return (port == 0) ? 12 : 3;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int pv, int pr);
    bit in_v, hit, out_free, rx_free, avail, exp_t0, exp_t1;
    int in_a, in_d, d0, d1;
    string ttag;
    @(negedge clk);
    in_v = ($urandom_range(99) < pv);
    case ($urandom_range(5))
      0: in_a = 5;
      1: in_a = 9;
      2: in_a = 0;
      3: in_a = 15;
      default: in_a = $urandom_range(15);
    endcase
    in_d = $urandom_range(255);
    d0 = $urandom_range(255);
    d1 = $urandom_range(255);
    ring_in_valid  = in_v;
    ring_in_addr   = in_a[3:0];
    ring_in_data   = in_d[7:0];
    tx_valid[0]    = ($urandom_range(99) < pv);
    tx_valid[1]    = ($urandom_range(99) < pv);
    tx_data        = {d1[7:0], d0[7:0]};
    ring_out_ready = ($urandom_range(99) < pr);
    rx_ready       = ($urandom_range(99) < pr);
    #1;
    // Registered outputs against model state
    check(m_out_held ? "R9" : m_out_tag, ring_out_valid, m_out_v);
    if (m_out_v) begin
      check(m_out_held ? "R9" : m_out_tag, ring_out_addr, m_out_a);
      check(m_out_held ? "R9" : m_out_tag, ring_out_data, m_out_d);
    end
    check(m_rx_held ? "R9" : "R2", rx_valid, m_rx_v);
    if (m_rx_v) begin
      check(m_rx_held ? "R9" : "R2", rx_addr, m_rx_a);
      check(m_rx_held ? "R9" : "R2", rx_data, m_rx_d);
    end
    // Combinational readies
    hit      = in_v && listed(in_a);
    out_free = !m_out_v || ring_out_ready;
    rx_free  = !m_rx_v || rx_ready;
    avail    = out_free && !(in_v && !hit);
    exp_t0   = avail;
    exp_t1   = avail && !tx_valid[0];
    if (in_v) check(hit ? (rx_free ? "R2" : "R8") : "R3", ring_in_ready, hit ? rx_free : out_free);
    if (in_v && !hit) ttag = "R4";
    else if (hit && !rx_free) ttag = "R10";
    else if (!out_free) ttag = "R5";
    else ttag = "R6";
    check(ttag, tx_ready[0], exp_t0);
    check(ttag, tx_ready[1], exp_t1);
    // Next model state
    m_out_held = m_out_v && !ring_out_ready;
    m_rx_held  = m_rx_v && !rx_ready;
    if (m_out_v && ring_out_ready) m_out_v = 0;
    if (m_rx_v && rx_ready) m_rx_v = 0;
    if (in_v && !hit && out_free) begin
      m_out_v = 1; m_out_a = in_a; m_out_d = in_d; m_out_tag = "R3"; m_out_held = 0;
    end else if (avail && tx_valid[0]) begin
      m_out_v = 1; m_out_a = stamp(0); m_out_d = d0; m_out_tag = "R7"; m_out_held = 0;
    end else if (avail && tx_valid[1]) begin
      m_out_v = 1; m_out_a = stamp(1); m_out_d = d1; m_out_tag = "R7"; m_out_held = 0;
    end
    if (hit && rx_free) begin
      m_rx_v = 1; m_rx_a = in_a; m_rx_d = in_d; m_rx_held = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ring_in_valid = 0; ring_in_addr = 0; ring_in_data = 0;
    tx_valid = 0; tx_data = 0; ring_out_ready = 0; rx_ready = 0;
    m_out_v = 0; m_rx_v = 0; m_out_a = 0; m_out_d = 0; m_rx_a = 0; m_rx_d = 0;
    m_out_held = 0; m_rx_held = 0; m_out_tag = "R3";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", ring_out_valid, 0);
    check("R1", rx_valid, 0);
    for (int n = 0; n < 1500; n++) step(70, 85);
    for (int n = 0; n < 1500; n++) step(90, 20);
    for (int n = 0; n < 1500; n++) step(50, 50);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule